// File: doc/BRIEF.md
# Dual-Channel Fractional Bit-Clock Divider

This block derives two periodic strobes from a single system clock. The first is the sampling strobe for an infrared serial link, nominally 1.8432 MHz. The second is the bit strobe for a UART whose divisor is a multiple of 16 clocks. Each channel has an integer divisor and a 4-bit correction value k. The correction stretches k out of every 16 periods by one clock, so the average period is the integer length plus k/16 of a clock. That fine step is what holds the infrared strobe within 1% of its target when the system clock is not an exact multiple of it.

Software programs the two channels through a write-only register bus with four 16-bit registers. A new setting is applied only at a period boundary, so a strobe period is never cut short. An integer field of zero in the infrared count register is illegal. It raises an error flag and silences the infrared strobe instead of being used as a divisor.

Top module: `sir_clkdiv`

## Requirements
- R1: A write with wr_en high lands on the next rising edge. Address 0 is the infrared count (bits [3:0] = divisor − 1). Address 1 is the infrared correction (k in bits [7:4]). Address 2 is the UART count (bits [7:0] = c). Address 3 is the UART correction (k in bits [7:4]).
- R2: With infrared count field n ≥ 1 and correction k, every interval between ir_tick pulses is n+1 or n+2 clocks. Any 16 consecutive intervals total exactly 16·(n+1)+k clocks.
- R3: With UART count field c and correction k, every interval between uart_tick pulses is (c+1)·16 or (c+1)·16+1 clocks. Any 16 consecutive intervals total exactly 16·(c+1)·16+k clocks.
- R4: With k = 0, every interval of that channel equals its base length exactly.
- R5: Each tick output is high for exactly one clock per generated period and is never high on two consecutive clocks.
- R6: An infrared count field of 0 sets cfg_err in the clock after the write edge. A nonzero field clears it in the clock after the write edge. While the field is 0, ir_tick stays low once the period in progress has ended. The UART channel keeps ticking.
- R7: A write does not alter the period in progress. The new setting governs the period that starts at the next tick of that channel.
- R8: When a channel applies a new setting, its fraction accumulator restarts from zero. With k = 15, the first period after the update is the base length and the second is one clock longer.
- R9: After reset, all four registers are zero. cfg_err is high, ir_tick stays low, and uart_tick repeats every 16 clocks.
- R10: Register bits outside the fields named in R1 have no effect on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (see R1) |
| wr_data | input | 16 | Register write data |
| ir_tick | output | 1 | One-clock infrared sampling strobe |
| uart_tick | output | 1 | One-clock UART bit strobe |
| cfg_err | output | 1 | Infrared count field is zero |

## Verification
The error flag is due in the clock after the write edge, so the bench samples it at the falling edge that closes the write. A tick is due only at a period boundary, and a setting is applied at the boundary after its write. For that reason the bench lets two ticks go by after programming before it measures. It then times intervals as differences of a rising-edge counter sampled at falling edges, so the tick phase at the start never enters a result. The boundary cases, an update during a long period and an update with k = 15, are checked interval by interval against the old and new lengths.

// File: rtl/sir_clkdiv_pkg.sv
package sir_clkdiv_pkg;

    localparam int REG_W      = 16;
    localparam int FRAC_W     = 4;
    localparam int FRAC_LSB   = 4;
    localparam int IR_CNT_W   = 4;
    localparam int UART_CNT_W = 8;
    localparam int OVS        = 16;

    localparam int OVS_SH     = $clog2(OVS);
    localparam int IR_LEN_W   = IR_CNT_W + 1;
    localparam int UART_LEN_W = UART_CNT_W + OVS_SH + 1;
    localparam int USED_W     = (UART_CNT_W > FRAC_LSB + FRAC_W) ? UART_CNT_W : FRAC_LSB + FRAC_W;

    typedef enum logic [1:0] {
        ADDR_IR_CNT    = 2'd0,
        ADDR_IR_FRAC   = 2'd1,
        ADDR_UART_CNT  = 2'd2,
        ADDR_UART_FRAC = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [IR_CNT_W-1:0] cnt;
        logic [FRAC_W-1:0]   frac;
    } ir_cfg_t;

    typedef struct packed {
        logic [UART_CNT_W-1:0] cnt;
        logic [FRAC_W-1:0]     frac;
    } uart_cfg_t;

    // Base period of the infrared channel in clocks: field + 1
    function automatic logic [IR_LEN_W-1:0] ir_len(input logic [IR_CNT_W-1:0] c);
        return IR_LEN_W'(c) + IR_LEN_W'(1);
    endfunction

    // Base period of the UART channel in clocks: (field + 1) * oversampling
    function automatic logic [UART_LEN_W-1:0] uart_len(input logic [UART_CNT_W-1:0] c);
        return (UART_LEN_W'(c) + UART_LEN_W'(1)) << OVS_SH;
    endfunction

    function automatic logic ir_legal(input logic [IR_CNT_W-1:0] c);
        return c != '0;
    endfunction

endpackage

// File: rtl/sir_clkdiv_regs.sv
module sir_clkdiv_regs
    import sir_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output ir_cfg_t          ir_cfg,
    output uart_cfg_t        uart_cfg,
    output logic             ir_load,
    output logic             uart_load
);

    reg_addr_e addr;
    logic      unused_upper;

    assign addr         = reg_addr_e'(wr_addr);
    assign unused_upper = ^wr_data[REG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_cfg   <= '0;
            uart_cfg <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_IR_CNT:    ir_cfg.cnt    <= wr_data[IR_CNT_W-1:0];
                ADDR_IR_FRAC:   ir_cfg.frac   <= wr_data[FRAC_LSB +: FRAC_W];
                ADDR_UART_CNT:  uart_cfg.cnt  <= wr_data[UART_CNT_W-1:0];
                ADDR_UART_FRAC: uart_cfg.frac <= wr_data[FRAC_LSB +: FRAC_W];
            endcase
        end
    end

    // A write to either register of a channel requests a reload there
    assign ir_load   = wr_en && (addr == ADDR_IR_CNT   || addr == ADDR_IR_FRAC);
    assign uart_load = wr_en && (addr == ADDR_UART_CNT || addr == ADDR_UART_FRAC);

endmodule

// File: rtl/sir_clkdiv_chan.sv
module sir_clkdiv_chan #(
    parameter int LEN_W  = 5,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [LEN_W-1:0]  prog_len,
    input  logic [FRAC_W-1:0] prog_frac,
    input  logic              prog_ok,
    output logic              tick
);

    logic [LEN_W-1:0]  ctr;
    logic [LEN_W-1:0]  act_len;
    logic [LEN_W-1:0]  use_len;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] act_frac;
    logic [FRAC_W-1:0] use_frac;
    logic [FRAC_W-1:0] use_acc;
    logic [FRAC_W:0]   sum;
    logic              act_ok;
    logic              use_ok;
    logic              pend;
    logic              bnd;

    always_comb begin
        bnd      = (ctr == '0);
        use_len  = pend ? prog_len  : act_len;
        use_frac = pend ? prog_frac : act_frac;
        use_ok   = pend ? prog_ok   : act_ok;
        use_acc  = pend ? '0        : acc;
        sum      = {1'b0, use_acc} + {1'b0, use_frac};
        tick     = bnd & act_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr      <= '0;
            acc      <= '0;
            act_len  <= '0;
            act_frac <= '0;
            act_ok   <= 1'b0;
            pend     <= 1'b1;
        end else if (bnd) begin
            act_len  <= use_len;
            act_frac <= use_frac;
            act_ok   <= use_ok;
            pend     <= load_req;
            if (use_ok) begin
                // carry out of the phase accumulator stretches this period
                ctr <= use_len - LEN_W'(1) + LEN_W'(sum[FRAC_W]);
                acc <= sum[FRAC_W-1:0];
            end else begin
                ctr <= '0;
                acc <= '0;
            end
        end else begin
            ctr  <= ctr - LEN_W'(1);
            pend <= pend | load_req;
        end
    end

endmodule

// File: rtl/sir_clkdiv.sv
module sir_clkdiv
    import sir_clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        ir_tick,
    output logic        uart_tick,
    output logic        cfg_err
);

    ir_cfg_t   ir_cfg;
    uart_cfg_t uart_cfg;
    logic      ir_load;
    logic      uart_load;
    logic      ir_ok;

    sir_clkdiv_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ir_cfg   (ir_cfg),
        .uart_cfg (uart_cfg),
        .ir_load  (ir_load),
        .uart_load(uart_load)
    );

    assign ir_ok   = ir_legal(ir_cfg.cnt);
    assign cfg_err = !ir_ok;

    sir_clkdiv_chan #(.LEN_W(IR_LEN_W), .FRAC_W(FRAC_W)) u_ir (
        .clk      (clk),
        .rst      (rst),
        .load_req (ir_load),
        .prog_len (ir_len(ir_cfg.cnt)),
        .prog_frac(ir_cfg.frac),
        .prog_ok  (ir_ok),
        .tick     (ir_tick)
    );

    sir_clkdiv_chan #(.LEN_W(UART_LEN_W), .FRAC_W(FRAC_W)) u_uart (
        .clk      (clk),
        .rst      (rst),
        .load_req (uart_load),
        .prog_len (uart_len(uart_cfg.cnt)),
        .prog_frac(uart_cfg.frac),
        .prog_ok  (1'b1),
        .tick     (uart_tick)
    );

endmodule

// File: rtl/sir_clkdiv_chk.sv
module sir_clkdiv_chk
    import sir_clkdiv_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [IR_CNT_W-1:0] cnt_field,
    input logic                ir_tick,
    input logic                uart_tick,
    input logic                cfg_err
);

    localparam int LIM = 2**IR_CNT_W + 2;

    logic [5:0] age;
    logic       cnt_wr;

    assign cnt_wr = wr_en && (wr_addr == ADDR_IR_CNT);

    always_ff @(posedge clk) begin
        if (rst || !cfg_err) age <= '0;
        else if (age != 6'(LIM)) age <= age + 6'd1;
    end

    AST_IR_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ir_tick |=> !ir_tick);                                          // R5
    AST_UART_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        uart_tick |=> !uart_tick);                                      // R5
    AST_ZERO_CNT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && cnt_field == '0) |=> cfg_err);                       // R6
    AST_CNT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && cnt_field != '0) |=> !cfg_err);                      // R6
    AST_ERR_SILENCES_IR: assert property (@(posedge clk) disable iff (rst)
        (age == 6'(LIM)) |-> !ir_tick);                                 // R6

endmodule

bind sir_clkdiv sir_clkdiv_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt_field(wr_data[sir_clkdiv_pkg::IR_CNT_W-1:0]),
    .ir_tick  (ir_tick),
    .uart_tick(uart_tick),
    .cfg_err  (cfg_err)
);

// File: tb/test_sir_clkdiv.sv
module test_sir_clkdiv;

    typedef struct packed {
        logic        uart;
        logic [15:0] cnt;
        logic [15:0] corr;
        int          base;
        int          k;
    } vec_t;

    // R1 field decode, R10 bits outside the fields carry junk in entries 3 and 6/7
    localparam vec_t VECS [8] = '{
        '{1'b0, 16'h0003, 16'h0040,  4,  4},   // R2
        '{1'b0, 16'h000F, 16'h00F0, 16, 15},   // R2
        '{1'b0, 16'h0001, 16'h0080,  2,  8},   // R2
        '{1'b0, 16'hFFF5, 16'hFF3F,  6,  3},   // R2 R10
        '{1'b1, 16'h0000, 16'h0050, 16,  5},   // R3
        '{1'b1, 16'h0002, 16'h0000, 48,  0},   // R4
        '{1'b1, 16'hFF01, 16'h00A0, 32, 10},   // R3 R10
        '{1'b0, 16'h0005, 16'h000F,  6,  0}    // R4 R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ir_tick;
    logic        uart_tick;
    logic        cfg_err;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    int b2b = 0;
    bit pir = 1'b0;
    bit pur = 1'b0;

    sir_clkdiv i_sir_clkdiv (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ir_tick(ir_tick), .uart_tick(uart_tick), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (ir_tick && pir) b2b++;
        if (uart_tick && pur) b2b++;
        pir = ir_tick;
        pur = uart_tick;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(input bit uart, output int t);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(uart ? uart_tick : ir_tick) && n < 20000);
        if (n >= 20000) chk(1'b0, "R2/R3 tick timeout", n, 0);
        t = cyc;
    endtask

    task summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        @(negedge clk);
        chk(cfg_err == 1'b1, "R9 cfg_err after reset", cfg_err, 1);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (ir_tick) cnt++; end
        chk(cnt == 0, "R9 ir_tick silent after reset", cnt, 0);
        wait_tick(1'b1, t0); wait_tick(1'b1, t1);
        chk(t1 - t0 == 16, "R9 uart period after reset", t1 - t0, 16);

        // Table of settings: R2 R3 R4 R1 R10
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            string tag;
            int t, tp, g, sum, mn, mx;
            v = VECS[i];
            tag = (v.k == 0) ? "R4" : (v.uart ? "R3" : "R2");
            wr(v.uart ? 2'd2 : 2'd0, v.cnt);
            wr(v.uart ? 2'd3 : 2'd1, v.corr);
            wait_tick(v.uart, t);
            wait_tick(v.uart, t);
            tp = t; sum = 0; mn = 1000000; mx = 0;
            for (int j = 0; j < 16; j++) begin
                wait_tick(v.uart, t);
                g = t - tp; tp = t; sum += g;
                if (g < mn) mn = g;
                if (g > mx) mx = g;
            end
            chk(sum == 16 * v.base + v.k, $sformatf("%s vec %0d total of 16 periods", tag, i), sum, 16 * v.base + v.k);
            chk(mn == v.base, $sformatf("%s vec %0d shortest period", tag, i), mn, v.base);
            chk(mx == v.base + ((v.k != 0) ? 1 : 0), $sformatf("%s vec %0d longest period", tag, i), mx, v.base + ((v.k != 0) ? 1 : 0));
        end

        // R7: a write during a long period leaves that period intact
        wr(2'd2, 16'h0003);
        wr(2'd3, 16'h0000);
        wait_tick(1'b1, t0); wait_tick(1'b1, t0);
        repeat (5) @(negedge clk);
        wr(2'd2, 16'h0000);
        wait_tick(1'b1, t1);
        chk(t1 - t0 == 64, "R7 period in progress keeps old length", t1 - t0, 64);
        wait_tick(1'b1, t2);
        chk(t2 - t1 == 16, "R7 next period uses new length", t2 - t1, 16);

        // R8: accumulator restarts from zero on an applied update
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'h00F0);
        wait_tick(1'b0, t0); wait_tick(1'b0, t0);
        wr(2'd1, 16'h00F0);
        wait_tick(1'b0, t1);
        wait_tick(1'b0, t2);
        chk(t2 - t1 == 4, "R8 first period after update", t2 - t1, 4);
        wait_tick(1'b0, t3);
        chk(t3 - t2 == 5, "R8 second period after update", t3 - t2, 5);

        // R6: zero infrared count flagged and silenced, UART unaffected
        wr(2'd1, 16'h0000);
        wait_tick(1'b0, t0); wait_tick(1'b0, t0);
        wr(2'd0, 16'h0000);
        chk(cfg_err == 1'b1, "R6 cfg_err after zero count", cfg_err, 1);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (ir_tick) cnt++; end
        chk(cnt <= 1, "R6 ticks while finishing current period", cnt, 1);
        cnt = 0;
        t1 = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ir_tick) cnt++;
            if (uart_tick) t1++;
        end
        chk(cnt == 0, "R6 ir_tick silent with zero count", cnt, 0);
        chk(t1 >= 3, "R6 uart keeps ticking", t1, 3);
        wr(2'd0, 16'h0003);
        chk(cfg_err == 1'b0, "R6 cfg_err cleared by nonzero count", cfg_err, 0);
        wait_tick(1'b0, t0); wait_tick(1'b0, t1); wait_tick(1'b0, t2);
        chk(t2 - t1 == 4, "R6 infrared resumes at base length", t2 - t1, 4);

        // R5: never two consecutive tick clocks on either channel
        chk(b2b == 0, "R5 single-clock ticks", b2b, 0);

        summary();
        $finish;
    end

endmodule